// File: doc/BRIEF.md
# Reset Boot Vector Fetch Sequencer

This block brings a processor board out of reset. Two active-low sources can start it: an internal power-up reset and a front-panel push-button. Either one is combined and synchronized inside the block. While any reset is present, and for the whole bring-up that follows, the sequencer withholds every exception grant: interrupt, trap, bus request and stop request. Grants are therefore only ever issued to a processor that has finished booting.

After reset is released, the sequencer spends one cycle issuing clear strobes. One goes to the system control register, which zeroes all its bits, including the translation-enable, segmented-user and parity/ECC-NMI bits. One goes to every MMU, which clears its mode, violation-type and descriptor-selection state but leaves its master enable alone. One goes to the serial channels, which turns off their receivers, transmitters and interrupts. The sequencer then opens the local memory window. Because translation is off, the reads that follow reach memory directly.

The sequencer then performs three word reads from segment 0 over a request/acknowledge interface. In order, these fetch the flag/control word, the program-counter segment number and the program-counter offset. In the cycle after the last read, it starts the first instruction fetch with the loaded segment and offset, pulses a done flag and releases the exception grants.

Top module: `boot_vector_seq`

## Requirements
- R1: While `por_n` or `btn_rst_n` is low, the block shows no activity: `mem_req`, `boot_done`, `fetch_go`, the three clear strobes, `local_mem_en` and `exc_gnt` are all 0. When both inputs are high, the reset is released through a two-stage synchronizer and the sequence starts. Either source alone starts the same sequence.
- R2: Each boot issues `scr_clr`, `mmu_clr` and `sio_clr` together in exactly one cycle, once, before the first vector read.
- R3: `local_mem_en` goes to 1 before the first vector read. It stays at 1 for every read and after the boot completes.
- R4: Exactly three reads are issued, all with `mem_seg` = 0, at word addresses 2, 4 and 6 in that order. Each request stays high with an unchanged address until `mem_ack` is seen.
- R5: Data is captured in the cycle `mem_ack` is high. `fcw` takes the first word. `pc_seg` takes bits 14:8 of the second word. `pc_off` takes the third word.
- R6: In the cycle after the third acknowledge, `fetch_go` and `boot_done` are both 1 for exactly one cycle, while `pc_seg` and `pc_off` present the loaded values.
- R7: `exc_gnt` is 0 during reset, during the sequence and in the fetch cycle. After that, each bit equals its request. Bit 0 is interrupt, bit 1 trap, bit 2 bus request and bit 3 stop request.
- R8: If a reset input is asserted in the middle of a sequence, the read in progress is abandoned at once (`mem_req` drops). On release, the sequence restarts from address 2.
- R9: After the boot completes, `mem_ack` has no effect: `fcw`, `pc_seg` and `pc_off` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low |
| btn_rst_n | input | 1 | Front-panel reset, active low |
| mem_req | output | 1 | Vector read request |
| mem_seg | output | 7 | Segment of the read (always 0) |
| mem_addr | output | 16 | Word address of the read |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Read data |
| local_mem_en | output | 1 | Local memory window enable |
| scr_clr | output | 1 | System control register clear strobe |
| mmu_clr | output | 1 | MMU mode/violation/descriptor clear strobe |
| sio_clr | output | 1 | Serial channel disable strobe |
| exc_req | input | 4 | Interrupt, trap, bus and stop requests |
| exc_gnt | output | 4 | Matching grants |
| boot_done | output | 1 | One-cycle boot completion flag |
| fetch_go | output | 1 | Start of the first instruction fetch |
| fcw | output | 16 | Loaded flag/control word |
| pc_seg | output | 7 | Loaded program-counter segment |
| pc_off | output | 16 | Loaded program-counter offset |

## Verification
The boot is run several times with different inputs. Some runs start from the power-up input and others from the button, which shows that either source starts the same sequence. Some runs acknowledge at once and others after long waits, which separates request holding from data capture. The vector words differ in every run, and the segment word carries extra bits outside bits 14:8, so a wrong field position or a swapped read order gives a visible mismatch. One run is cut by a reset in the middle of its second read, to show the restart from address 2. A stray acknowledge after the boot shows that the captured values are frozen.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

   typedef enum logic [2:0] {
      ST_HOLD   = 3'd0,
      ST_CLEAR  = 3'd1,
      ST_RD_FCW = 3'd2,
      ST_RD_SEG = 3'd3,
      ST_RD_OFF = 3'd4,
      ST_FETCH  = 3'd5,
      ST_RUN    = 3'd6
   } boot_st_e;

   function automatic logic st_is_read(boot_st_e s);
      return (s == ST_RD_FCW) || (s == ST_RD_SEG) || (s == ST_RD_OFF);
   endfunction

endpackage

// File: rtl/boot_rst_sync.sv
`timescale 1ns/1ps
module boot_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic btn_rst_n,
   output logic rst_sn
);
   if (STAGES < 2) begin : g_bad_stages
      $error("boot_rst_sync: STAGES must be at least 2");
   end

   logic any_rst_n;
   logic [STAGES-1:0] chain;

   assign any_rst_n = por_n & btn_rst_n;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge any_rst_n) begin
            if (!any_rst_n) chain[g] <= 1'b0;
            else            chain[g] <= 1'b1;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge any_rst_n) begin
            if (!any_rst_n) chain[g] <= 1'b0;
            else            chain[g] <= chain[g-1];
         end
      end
   end

   assign rst_sn = chain[STAGES-1];
endmodule

// File: rtl/boot_exc_gate.sv
`timescale 1ns/1ps
module boot_exc_gate #(
   parameter int N_EXC = 4
) (
   input  logic             busy,
   input  logic [N_EXC-1:0] req,
   output logic [N_EXC-1:0] gnt
);
   if (N_EXC < 1) begin : g_bad_n
      $error("boot_exc_gate: N_EXC must be positive");
   end

   for (genvar g = 0; g < N_EXC; g++) begin : g_bit
      assign gnt[g] = req[g] & ~busy;
   end
endmodule

// File: rtl/boot_vec_fsm.sv
`timescale 1ns/1ps
module boot_vec_fsm
   import boot_seq_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int SEG_W    = 7,
   parameter int SEG_LSB  = 8,
   parameter int FCW_ADDR = 2,
   parameter int SEG_ADDR = 4,
   parameter int OFF_ADDR = 6
) (
   input  logic              clk,
   input  logic              rst_sn,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              scr_clr,
   output logic              mmu_clr,
   output logic              sio_clr,
   output logic              local_mem_en,
   output logic              seq_busy,
   output logic              boot_done,
   output logic              fetch_go,
   output logic [DATA_W-1:0] fcw_q,
   output logic [SEG_W-1:0]  pc_seg_q,
   output logic [DATA_W-1:0] pc_off_q
);
   localparam int MAX_ADDR = (1 << ADDR_W) - 1;

   if (SEG_LSB + SEG_W > DATA_W) begin : g_bad_seg
      $error("boot_vec_fsm: segment field exceeds data width");
   end
   if (OFF_ADDR > MAX_ADDR) begin : g_bad_addr
      $error("boot_vec_fsm: vector address exceeds address width");
   end

   boot_st_e state, state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_HOLD:   state_nx = ST_CLEAR;
         ST_CLEAR:  state_nx = ST_RD_FCW;
         ST_RD_FCW: if (mem_ack) state_nx = ST_RD_SEG;
         ST_RD_SEG: if (mem_ack) state_nx = ST_RD_OFF;
         ST_RD_OFF: if (mem_ack) state_nx = ST_FETCH;
         ST_FETCH:  state_nx = ST_RUN;
         ST_RUN:    state_nx = ST_RUN;
         default:   state_nx = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) state <= ST_HOLD;
      else         state <= state_nx;
   end

   always_comb begin
      unique case (state)
         ST_RD_FCW: mem_addr = ADDR_W'(FCW_ADDR);
         ST_RD_SEG: mem_addr = ADDR_W'(SEG_ADDR);
         ST_RD_OFF: mem_addr = ADDR_W'(OFF_ADDR);
         default:   mem_addr = '0;
      endcase
   end

   assign mem_req   = st_is_read(state);
   assign scr_clr   = (state == ST_CLEAR);
   assign mmu_clr   = (state == ST_CLEAR);
   assign sio_clr   = (state == ST_CLEAR);
   assign boot_done = (state == ST_FETCH);
   assign fetch_go  = (state == ST_FETCH);
   assign seq_busy  = (state != ST_RUN);

   always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)                local_mem_en <= 1'b0;
      else if (state == ST_CLEAR) local_mem_en <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) begin
         fcw_q    <= '0;
         pc_seg_q <= '0;
         pc_off_q <= '0;
      end else if (mem_ack) begin
         if (state == ST_RD_FCW) fcw_q    <= mem_rdata;
         if (state == ST_RD_SEG) pc_seg_q <= mem_rdata[SEG_LSB +: SEG_W];
         if (state == ST_RD_OFF) pc_off_q <= mem_rdata;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4
   AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
      scr_clr |=> !scr_clr); // R2
   AST_LMEM_ON: assert property (@(posedge clk) disable iff (!rst_sn)
      mem_req |-> local_mem_en); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
      boot_done |=> !boot_done); // R6
   AST_RUN_FROZEN: assert property (@(posedge clk) disable iff (!rst_sn)
      (state == ST_RUN) |=> ($stable(fcw_q) && $stable(pc_seg_q) && $stable(pc_off_q))); // R9
endmodule

// File: rtl/boot_vector_seq.sv
`timescale 1ns/1ps
module boot_vector_seq #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int SEG_W       = 7,
   parameter int SEG_LSB     = 8,
   parameter int BOOT_SEG    = 0,
   parameter int FCW_ADDR    = 2,
   parameter int SEG_ADDR    = 4,
   parameter int OFF_ADDR    = 6,
   parameter int SYNC_STAGES = 2,
   parameter int N_EXC       = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              btn_rst_n,
   output logic              mem_req,
   output logic [SEG_W-1:0]  mem_seg,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              local_mem_en,
   output logic              scr_clr,
   output logic              mmu_clr,
   output logic              sio_clr,
   input  logic [N_EXC-1:0]  exc_req,
   output logic [N_EXC-1:0]  exc_gnt,
   output logic              boot_done,
   output logic              fetch_go,
   output logic [DATA_W-1:0] fcw,
   output logic [SEG_W-1:0]  pc_seg,
   output logic [DATA_W-1:0] pc_off
);
   if (BOOT_SEG >= (1 << SEG_W)) begin : g_bad_bseg
      $error("boot_vector_seq: BOOT_SEG does not fit SEG_W");
   end

   logic rst_sn;
   logic seq_busy;

   boot_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .por_n(por_n), .btn_rst_n(btn_rst_n), .rst_sn(rst_sn)
   );

   boot_vec_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W), .SEG_LSB(SEG_LSB),
      .FCW_ADDR(FCW_ADDR), .SEG_ADDR(SEG_ADDR), .OFF_ADDR(OFF_ADDR)
   ) i_fsm (
      .clk(clk), .rst_sn(rst_sn),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .scr_clr(scr_clr), .mmu_clr(mmu_clr), .sio_clr(sio_clr),
      .local_mem_en(local_mem_en), .seq_busy(seq_busy),
      .boot_done(boot_done), .fetch_go(fetch_go),
      .fcw_q(fcw), .pc_seg_q(pc_seg), .pc_off_q(pc_off)
   );

   boot_exc_gate #(.N_EXC(N_EXC)) i_gate (
      .busy(seq_busy), .req(exc_req), .gnt(exc_gnt)
   );

   assign mem_seg = SEG_W'(BOOT_SEG);

   AST_NO_GNT_READ: assert property (@(posedge clk) disable iff (!rst_sn)
      mem_req |-> (exc_gnt == '0)); // R7
   AST_NO_GNT_FETCH: assert property (@(posedge clk) disable iff (!rst_sn)
      fetch_go |-> (exc_gnt == '0)); // R7
   AST_CLR_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_sn)
      scr_clr |-> (!mem_req && !local_mem_en)); // R2
endmodule

// File: tb/test_boot_vector_seq.sv
`timescale 1ns/1ps
module test_boot_vector_seq;
   logic        clk = 1'b0;
   logic        por_n, btn_rst_n, mem_ack;
   logic [15:0] mem_rdata;
   logic [3:0]  exc_req;
   logic        mem_req, local_mem_en, scr_clr, mmu_clr, sio_clr, boot_done, fetch_go;
   logic [6:0]  mem_seg, pc_seg;
   logic [15:0] mem_addr, fcw, pc_off;
   logic [3:0]  exc_gnt;

   int n_tests = 0;
   int n_fail  = 0;
   int ack_dly = 0;
   int clr_cnt = 0;
   logic [15:0] exp_q[$];
   logic [15:0] vmem [0:3];

   always #2 clk = ~clk;

   boot_vector_seq i_boot_vector_seq (
      .clk(clk), .por_n(por_n), .btn_rst_n(btn_rst_n),
      .mem_req(mem_req), .mem_seg(mem_seg), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .local_mem_en(local_mem_en),
      .scr_clr(scr_clr), .mmu_clr(mmu_clr), .sio_clr(sio_clr),
      .exc_req(exc_req), .exc_gnt(exc_gnt), .boot_done(boot_done),
      .fetch_go(fetch_go), .fcw(fcw), .pc_seg(pc_seg), .pc_off(pc_off)
   );

   task automatic chk(input string rq, input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // strobe monitor
   always @(negedge clk) begin
      if (scr_clr || mmu_clr || sio_clr) begin
         clr_cnt++;
         chk("R2", "strobes together", {scr_clr, mmu_clr, sio_clr}, 3'b111);
      end
   end

   // memory responder and scoreboard monitor
   initial begin
      mem_ack = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_req && !mem_ack) begin
            logic [15:0] e;
            bit abort;
            e = (exp_q.size() != 0) ? exp_q.pop_front() : 16'hFFFF;
            chk("R4", "read address", mem_addr, e);
            chk("R4", "read segment", mem_seg, 0);
            chk("R3", "local mem on during read", local_mem_en, 1);
            chk("R7", "no grant during read", exc_gnt, 0);
            if (e == 16'd2) chk("R2", "strobe before first read", clr_cnt, 1);
            abort = 1'b0;
            for (int i = 0; i < ack_dly; i++) begin
               @(negedge clk);
               if (!por_n || !btn_rst_n) begin
                  abort = 1'b1;
                  break;
               end
               chk("R4", "request held", {mem_req, mem_addr}, {1'b1, e});
            end
            if (!abort) begin
               mem_rdata = vmem[mem_addr[2:1]];
               mem_ack = 1'b1;
               @(negedge clk);
               mem_ack = 1'b0;
            end
         end
      end
   end

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (boot_done) begin
            seen = 1'b1;
            break;
         end
      end
   endtask

   task automatic check_after(input logic [15:0] f, input logic [15:0] s, input logic [15:0] o);
      chk("R6", "fetch_go with done", fetch_go, 1);
      chk("R5", "fcw loaded", fcw, f);
      chk("R5", "segment bits 14:8", pc_seg, s[14:8]);
      chk("R5", "offset loaded", pc_off, o);
      chk("R4", "all three reads used", exp_q.size(), 0);
      chk("R2", "one strobe per boot", clr_cnt, 1);
      chk("R7", "no grant in fetch cycle", exc_gnt, 0);
      @(negedge clk);
      chk("R6", "done is one cycle", {boot_done, fetch_go}, 2'b00);
      chk("R7", "grants follow requests", exc_gnt, exc_req);
      chk("R3", "local mem stays on", local_mem_en, 1);
      exc_req = 4'b0101;
      @(negedge clk);
      chk("R7", "grant pattern 0101", exc_gnt, 4'b0101);
      exc_req = 4'b1111;
   endtask

   task automatic run_boot(input bit use_por, input logic [15:0] f, input logic [15:0] s,
                           input logic [15:0] o, input int dly);
      bit seen;
      vmem[1] = f; vmem[2] = s; vmem[3] = o;
      ack_dly = dly;
      exp_q.delete();
      exp_q.push_back(16'd2); exp_q.push_back(16'd4); exp_q.push_back(16'd6);
      @(negedge clk);
      if (use_por) por_n = 1'b0; else btn_rst_n = 1'b0;
      exc_req = 4'b1111;
      repeat (3) @(negedge clk);
      chk("R1", "quiet in reset",
          {mem_req, boot_done, fetch_go, scr_clr, mmu_clr, sio_clr, local_mem_en}, 0);
      chk("R1", "no grant in reset", exc_gnt, 0);
      clr_cnt = 0;
      por_n = 1'b1; btn_rst_n = 1'b1;
      wait_done(seen);
      chk("R1", "sequence completes after release", seen, 1);
      if (seen) check_after(f, s, o);
   endtask

   initial begin
      bit seen;
      por_n = 1'b0; btn_rst_n = 1'b1; exc_req = 4'b1111;
      repeat (4) @(negedge clk);
      chk("R1", "reset state outputs",
          {mem_req, boot_done, fetch_go, scr_clr, local_mem_en, exc_gnt}, 0);

      run_boot(1'b1, 16'h4000, 16'hA5C3, 16'h0100, 0);
      run_boot(1'b0, 16'h1234, 16'h7F00, 16'hFFFE, 3);
      run_boot(1'b1, 16'hC0DE, 16'h80FF, 16'h0000, 7);

      // R9: stray acknowledge after boot
      @(negedge clk);
      mem_rdata = 16'hDEAD;
      mem_ack = 1'b1;
      repeat (3) @(negedge clk);
      mem_ack = 1'b0;
      @(negedge clk);
      chk("R9", "fcw unchanged by stray ack", fcw, 16'hC0DE);
      chk("R9", "segment unchanged by stray ack", pc_seg, 7'h00);
      chk("R9", "offset unchanged by stray ack", pc_off, 16'h0000);
      chk("R9", "no request after boot", mem_req, 0);

      // R8: reset in the middle of the second read
      vmem[1] = 16'h1111; vmem[2] = 16'h2200; vmem[3] = 16'h3333;
      ack_dly = 30;
      exp_q.delete();
      exp_q.push_back(16'd2); exp_q.push_back(16'd4); exp_q.push_back(16'd6);
      btn_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      clr_cnt = 0;
      btn_rst_n = 1'b1;
      seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (mem_req && mem_addr == 16'd4) begin
            seen = 1'b1;
            break;
         end
      end
      chk("R8", "second read reached", seen, 1);
      @(posedge clk);
      #1 btn_rst_n = 1'b0;
      @(negedge clk);
      chk("R8", "request dropped on reset", {mem_req, boot_done}, 2'b00);
      repeat (2) @(negedge clk);
      exp_q.delete();
      exp_q.push_back(16'd2); exp_q.push_back(16'd4); exp_q.push_back(16'd6);
      ack_dly = 1;
      clr_cnt = 0;
      btn_rst_n = 1'b1;
      seen = 1'b0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (mem_req) begin
            seen = 1'b1;
            break;
         end
      end
      chk("R8", "restart at address 2", {seen, mem_addr}, {1'b1, 16'd2});
      wait_done(seen);
      chk("R8", "restarted boot completes", seen, 1);
      if (seen) check_after(16'h1111, 16'h2200, 16'h3333);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL all: watchdog expired, actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule